// File: doc/BRIEF.md
# CCD Vertical Frame Mode Sequencer

This block tracks the line position inside a vertical frame of a frame-transfer CCD. It supports two readout modes. In still mode the sensor is read at full resolution. In monitor mode the sensor produces a reduced-height preview. Each time the `line_start` strobe arrives, the block advances its line count. It then decides whether the new line carries a charge-reset pulse and whether vertical line shifts run during it. It also flags whether the line holds active picture rows. A one-cycle flag marks the start of each frame.

In monitor mode the block also launches a fast frame-shift burst when it enters line 1. The burst steps through every image row at a divided rate. It marks two out of every ten active rows as kept, and it discards the storage gap rows at the end.

A downstream vertical pulse generator consumes the enables. A mode change and a new exposure setting take effect only at a frame boundary. The exposure setting is given as the line on which charge reset fires.

Top module: `ccd_frame_seq`

## Requirements
- R1: While `rst` is high, the outputs settle at the next clock edge. `line_cnt` goes to 0. `frame_start`, `cr_en`, `line_shift_en`, `line_valid`, `fs_active` and `fs_row` go to 0. `mode_mon` takes the value of `mode_sel`, where 1 selects monitor and 0 selects still.
- R2: Each cycle with `line_start` high, `line_cnt` advances by one, and the new value appears after that edge. The count wraps to 0 after line 2034 in still mode and after line 314 in monitor mode. `frame_start` is high for exactly the one cycle after the wrapping edge.
- R3: `mode_sel` and `integ_line` are sampled only at reset and at the wrapping edge. Changes at any other time have no effect on `mode_mon`, `cr_en` or the frame length until the next wrap.
- R4: `cr_en` is a one-cycle pulse on entry to the charge-reset line. That line is the sampled `integ_line` when it lies in 1 to 1628 (still mode) or 1 to 113 (monitor mode). Otherwise the charge-reset line is 1628 or 113 respectively.
- R5: `line_shift_en` is high during lines 2 to 1626 in still mode and during lines 2 to 314 in monitor mode. It is low on every other line.
- R6: `line_valid` is high during lines 324 to 1603 in still mode (1280 lines) and during lines 18 to 275 in monitor mode (258 lines). It is low on every other line.
- R7: Entering line 1 in monitor mode starts a burst. `fs_active` is high from the next cycle for 1330×FS_DIV cycles. Still mode never starts a burst.
- R8: During a burst, `fs_row` pulses for one cycle every FS_DIV cycles. The first pulse comes FS_DIV cycles after the start edge, and there are 1330 pulses in all.
- R9: `fs_keep` accompanies each `fs_row` pulse. Row indices run 0 to 1329. Rows 0 to 15 are kept. Within rows 16 to 1305, a row r is kept when (r−16) mod 10 is 0 or 1. Rows 1306 to 1323 are kept. Rows 1324 to 1329 are discarded. A burst therefore keeps 292 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Requested mode: 0 still, 1 monitor |
| line_start | input | 1 | One-cycle strobe at each line boundary |
| integ_line | input | 11 | Requested charge-reset (exposure start) line |
| line_cnt | output | 11 | Current line within the frame |
| frame_start | output | 1 | One-cycle flag on wrap to line 0 |
| cr_en | output | 1 | Charge-reset pulse |
| line_shift_en | output | 1 | Vertical line shifts enabled for this line |
| line_valid | output | 1 | Line carries active picture rows |
| mode_mon | output | 1 | Mode in force for the current frame |
| fs_active | output | 1 | Frame-shift burst in progress |
| fs_row | output | 1 | One image row transferred in the burst |
| fs_keep | output | 1 | Row accompanying `fs_row` is kept |

## Verification
Every line-driven output is registered at the edge that samples `line_start`. It is compared at the falling edge that follows, against a behavioural model that advances at the same rising edge. Burst outputs are due a fixed number of edges after the start edge: row k (counting from 1) arrives exactly k×FS_DIV edges later. The model derives these from the elapsed edge count rather than from a divider of its own. At the end of each burst, the bench also counts total and kept rows. Mode and exposure changes are applied in mid-frame so that the sampling points are tested.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic {
    MODE_STILL = 1'b0,
    MODE_MON   = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/ccd_line_ctl.sv
module ccd_line_ctl
  import ccd_seq_pkg::*;
#(
  parameter int CNT_W          = 11,
  parameter int STILL_LEN      = 2035,
  parameter int MON_LEN        = 315,
  parameter int STILL_CR       = 1628,
  parameter int MON_CR         = 113,
  parameter int SHIFT_FIRST    = 2,
  parameter int STILL_SH_LAST  = 1626,
  parameter int MON_SH_LAST    = 314,
  parameter int STILL_ACT_FIRST = 324,
  parameter int STILL_ACT_LINES = 1280,
  parameter int MON_ACT_FIRST  = 18,
  parameter int MON_ACT_LINES  = 258
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] integ_line,
  output logic [CNT_W-1:0] line_cnt,
  output logic             mode_mon,
  output logic             frame_start,
  output logic             cr_en,
  output logic             line_shift_en,
  output logic             line_valid,
  output logic             burst_go
);
  localparam logic [CNT_W-1:0] L_STILL_LEN = CNT_W'(STILL_LEN);
  localparam logic [CNT_W-1:0] L_MON_LEN   = CNT_W'(MON_LEN);
  localparam logic [CNT_W-1:0] L_STILL_CR  = CNT_W'(STILL_CR);
  localparam logic [CNT_W-1:0] L_MON_CR    = CNT_W'(MON_CR);
  localparam logic [CNT_W-1:0] L_SH_FIRST  = CNT_W'(SHIFT_FIRST);
  localparam logic [CNT_W-1:0] L_STILL_SHL = CNT_W'(STILL_SH_LAST);
  localparam logic [CNT_W-1:0] L_MON_SHL   = CNT_W'(MON_SH_LAST);
  localparam logic [CNT_W-1:0] L_STILL_AF  = CNT_W'(STILL_ACT_FIRST);
  localparam logic [CNT_W-1:0] L_STILL_AL  = CNT_W'(STILL_ACT_FIRST + STILL_ACT_LINES - 1);
  localparam logic [CNT_W-1:0] L_MON_AF    = CNT_W'(MON_ACT_FIRST);
  localparam logic [CNT_W-1:0] L_MON_AL    = CNT_W'(MON_ACT_FIRST + MON_ACT_LINES - 1);
  localparam logic [CNT_W-1:0] L_ONE       = CNT_W'(1);

  seq_mode_e        mode_q, mode_nxt, mode_req;
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_nxt, frame_len;
  logic [CNT_W-1:0] cr_q, cr_nxt, cr_req;
  logic             wrap;
  logic             sh_nxt, val_nxt;

  function automatic logic [CNT_W-1:0] pick_cr(input seq_mode_e m,
                                                input logic [CNT_W-1:0] req);
    logic [CNT_W-1:0] lim;
    lim = (m == MODE_MON) ? L_MON_CR : L_STILL_CR;
    return ((req == '0) || (req > lim)) ? lim : req;
  endfunction

  always_comb begin
    mode_req  = seq_mode_e'(mode_sel);
    cr_req    = pick_cr(mode_req, integ_line);
    frame_len = (mode_q == MODE_MON) ? L_MON_LEN : L_STILL_LEN;
    cnt_inc   = cnt_q + L_ONE;
    wrap      = (cnt_inc == frame_len);
    cnt_nxt   = wrap ? '0 : cnt_inc;
    mode_nxt  = wrap ? mode_req : mode_q;
    cr_nxt    = wrap ? cr_req : cr_q;
    if (mode_nxt == MODE_MON) begin
      sh_nxt  = (cnt_nxt >= L_SH_FIRST) && (cnt_nxt <= L_MON_SHL);
      val_nxt = (cnt_nxt >= L_MON_AF) && (cnt_nxt <= L_MON_AL);
    end else begin
      sh_nxt  = (cnt_nxt >= L_SH_FIRST) && (cnt_nxt <= L_STILL_SHL);
      val_nxt = (cnt_nxt >= L_STILL_AF) && (cnt_nxt <= L_STILL_AL);
    end
  end

  assign burst_go = line_start && !rst && (mode_nxt == MODE_MON) && (cnt_nxt == L_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      mode_q        <= mode_req;
      cr_q          <= cr_req;
      frame_start   <= 1'b0;
      cr_en         <= 1'b0;
      line_shift_en <= 1'b0;
      line_valid    <= 1'b0;
    end else if (line_start) begin
      cnt_q         <= cnt_nxt;
      mode_q        <= mode_nxt;
      cr_q          <= cr_nxt;
      frame_start   <= wrap;
      cr_en         <= (cnt_nxt == cr_nxt);
      line_shift_en <= sh_nxt;
      line_valid    <= val_nxt;
    end else begin
      frame_start   <= 1'b0;
      cr_en         <= 1'b0;
    end
  end

  assign line_cnt = cnt_q;
  assign mode_mon = (mode_q == MODE_MON);

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (cnt_q == '0));
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < frame_len);
  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> frame_start);
  // R4
  cr_single_chk: assert property (@(posedge clk) disable iff (rst)
    cr_en |=> !cr_en);
  // R6
  valid_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> line_shift_en);
endmodule

// File: rtl/ccd_fs_burst.sv
module ccd_fs_burst #(
  parameter int FS_DIV     = 16,
  parameter int LEAD_ROWS  = 16,
  parameter int SUB_ROWS   = 1290,
  parameter int TAIL_ROWS  = 18,
  parameter int GAP_ROWS   = 6,
  parameter int SUB_KEEP   = 2,
  parameter int SUB_PERIOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fs_active,
  output logic fs_row,
  output logic fs_keep
);
  localparam int ROWS   = LEAD_ROWS + SUB_ROWS + TAIL_ROWS + GAP_ROWS;
  localparam int ROW_W  = $clog2(ROWS + 1);
  localparam int DIV_W  = $clog2(FS_DIV);
  localparam int PH_W   = $clog2(SUB_PERIOD);
  localparam logic [ROW_W-1:0] R_SUB_FIRST  = ROW_W'(LEAD_ROWS);
  localparam logic [ROW_W-1:0] R_TAIL_FIRST = ROW_W'(LEAD_ROWS + SUB_ROWS);
  localparam logic [ROW_W-1:0] R_GAP_FIRST  = ROW_W'(LEAD_ROWS + SUB_ROWS + TAIL_ROWS);
  localparam logic [ROW_W-1:0] R_LAST       = ROW_W'(ROWS - 1);
  localparam logic [ROW_W-1:0] R_ONE        = ROW_W'(1);
  localparam logic [DIV_W-1:0] D_LAST       = DIV_W'(FS_DIV - 1);
  localparam logic [DIV_W-1:0] D_ONE        = DIV_W'(1);
  localparam logic [PH_W-1:0]  P_LAST       = PH_W'(SUB_PERIOD - 1);
  localparam logic [PH_W-1:0]  P_KEEP       = PH_W'(SUB_KEEP);
  localparam logic [PH_W-1:0]  P_ONE        = PH_W'(1);

  logic             act_q;
  logic [DIV_W-1:0] div_q;
  logic [ROW_W-1:0] row_q;
  logic [PH_W-1:0]  ph_q;
  logic             in_sub, keep_now;

  always_comb begin
    in_sub = (row_q >= R_SUB_FIRST) && (row_q < R_TAIL_FIRST);
    if (row_q < R_SUB_FIRST)      keep_now = 1'b1;
    else if (in_sub)              keep_now = (ph_q < P_KEEP);
    else if (row_q < R_GAP_FIRST) keep_now = 1'b1;
    else                          keep_now = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      div_q   <= '0;
      row_q   <= '0;
      ph_q    <= '0;
      fs_row  <= 1'b0;
      fs_keep <= 1'b0;
    end else if (start) begin
      act_q   <= 1'b1;
      div_q   <= '0;
      row_q   <= '0;
      ph_q    <= '0;
      fs_row  <= 1'b0;
      fs_keep <= 1'b0;
    end else begin
      fs_row <= 1'b0;
      if (act_q) begin
        if (div_q == D_LAST) begin
          div_q   <= '0;
          fs_row  <= 1'b1;
          fs_keep <= keep_now;
          row_q   <= row_q + R_ONE;
          if (in_sub) ph_q <= (ph_q == P_LAST) ? '0 : ph_q + P_ONE;
          if (row_q == R_LAST) act_q <= 1'b0;
        end else begin
          div_q <= div_q + D_ONE;
        end
      end
    end
  end

  assign fs_active = act_q;

  // R7
  start_act_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> act_q);
  // R8
  row_in_burst_chk: assert property (@(posedge clk) disable iff (rst)
    fs_row |-> $past(act_q));
  // R8
  row_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    fs_row |=> !fs_row);
  // R8
  row_bound_chk: assert property (@(posedge clk) disable iff (rst)
    row_q <= ROW_W'(ROWS));
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
  parameter int CNT_W      = 11,
  parameter int FS_DIV     = 16,
  parameter int SUB_KEEP   = 2,
  parameter int SUB_PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             line_start,
  input  logic [CNT_W-1:0] integ_line,
  output logic [CNT_W-1:0] line_cnt,
  output logic             frame_start,
  output logic             cr_en,
  output logic             line_shift_en,
  output logic             line_valid,
  output logic             mode_mon,
  output logic             fs_active,
  output logic             fs_row,
  output logic             fs_keep
);
  logic burst_go;

  ccd_line_ctl #(
    .CNT_W(CNT_W)
  ) u_line (
    .clk          (clk),
    .rst          (rst),
    .line_start   (line_start),
    .mode_sel     (mode_sel),
    .integ_line   (integ_line),
    .line_cnt     (line_cnt),
    .mode_mon     (mode_mon),
    .frame_start  (frame_start),
    .cr_en        (cr_en),
    .line_shift_en(line_shift_en),
    .line_valid   (line_valid),
    .burst_go     (burst_go)
  );

  ccd_fs_burst #(
    .FS_DIV    (FS_DIV),
    .SUB_KEEP  (SUB_KEEP),
    .SUB_PERIOD(SUB_PERIOD)
  ) u_burst (
    .clk      (clk),
    .rst      (rst),
    .start    (burst_go),
    .fs_active(fs_active),
    .fs_row   (fs_row),
    .fs_keep  (fs_keep)
  );
endmodule

// File: tb/ccd_frame_seq_tb.sv
module ccd_frame_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int ROWS = 1330;
  localparam int WATCHDOG = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_sel = 1'b0;
  logic        line_start = 1'b0;
  logic [10:0] integ_line = '0;
  logic [10:0] line_cnt;
  logic frame_start, cr_en, line_shift_en, line_valid, mode_mon;
  logic fs_active, fs_row, fs_keep;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_frame_seq #(.FS_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .line_start(line_start),
    .integ_line(integ_line), .line_cnt(line_cnt), .frame_start(frame_start),
    .cr_en(cr_en), .line_shift_en(line_shift_en), .line_valid(line_valid),
    .mode_mon(mode_mon), .fs_active(fs_active), .fs_row(fs_row), .fs_keep(fs_keep)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int pick(input int m, input int req);
    int lim;
    lim = m ? 113 : 1628;
    return (req == 0 || req > lim) ? lim : req;
  endfunction

  function automatic int keep_of(input int k);
    if (k < 16) return 1;
    if (k < 1306) return (((k - 16) % 10) < 2) ? 1 : 0;
    if (k < 1324) return 1;
    return 0;
  endfunction

  // behavioural reference model
  int cyc = 0;
  int m_cnt, m_mode, m_cr, m_fs, m_cre, m_sh, m_val;
  int t0 = -10000000;
  always @(posedge clk) begin
    int nxt;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_mode = mode_sel; m_cr = pick(mode_sel, integ_line);
      m_fs = 0; m_cre = 0; m_sh = 0; m_val = 0; t0 = -10000000;
    end else begin
      m_fs = 0; m_cre = 0;
      if (line_start) begin
        nxt = m_cnt + 1;
        if (nxt == (m_mode ? 315 : 2035)) begin
          nxt = 0; m_mode = mode_sel; m_cr = pick(mode_sel, integ_line); m_fs = 1;
        end
        m_cnt = nxt;
        m_cre = (m_cnt == m_cr);
        m_sh  = (m_cnt >= 2) && (m_cnt <= (m_mode ? 314 : 1626));
        m_val = m_mode ? (m_cnt >= 18 && m_cnt <= 275) : (m_cnt >= 324 && m_cnt <= 1603);
        if (m_mode == 1 && m_cnt == 1) t0 = cyc;
      end
    end
  end

  int rows_seen = 0, kept_seen = 0;
  always @(negedge clk) begin
    int d, e_act, e_row;
    if (cyc > 0) begin
      d = cyc - t0;
      e_act = (d >= 0) && (d < ROWS * DIV);
      e_row = (d > 0) && (d % DIV == 0) && (d / DIV <= ROWS);
      chk(line_cnt == m_cnt, "R2", "line_cnt", line_cnt, m_cnt);
      chk(frame_start == m_fs, "R2", "frame_start", frame_start, m_fs);
      chk(mode_mon == m_mode, "R3", "mode_mon", mode_mon, m_mode);
      chk(cr_en == m_cre, "R4", "cr_en", cr_en, m_cre);
      chk(line_shift_en == m_sh, "R5", "line_shift_en", line_shift_en, m_sh);
      chk(line_valid == m_val, "R6", "line_valid", line_valid, m_val);
      chk(fs_active == e_act, "R7", "fs_active", fs_active, e_act);
      chk(fs_row == e_row, "R8", "fs_row", fs_row, e_row);
      if (e_row) begin
        chk(fs_keep == keep_of(d / DIV - 1), "R9", "fs_keep", fs_keep, keep_of(d / DIV - 1));
      end
      if (d == 0) begin rows_seen = 0; kept_seen = 0; end
      if (fs_row) begin rows_seen++; if (fs_keep) kept_seen++; end
      if (d == ROWS * DIV) begin
        chk(rows_seen == ROWS, "R8", "burst row count", rows_seen, ROWS);
        chk(kept_seen == 292, "R9", "kept row count", kept_seen, 292);
      end
    end
  end

  task automatic lines(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_cnt == 0, "R1", "reset line_cnt", line_cnt, 0);
    chk({frame_start, cr_en, line_shift_en, line_valid, fs_active, fs_row} == 6'b0,
        "R1", "reset flags", {frame_start, cr_en, line_shift_en, line_valid, fs_active, fs_row}, 0);
    chk(mode_mon == 1'b0, "R1", "reset mode", mode_mon, 0);
    rst = 1'b0;
    // still frame, default reset line; mid-frame change must wait (R3)
    lines(1000, 8);
    mode_sel = 1'b1; integ_line = 11'd50;
    lines(1035, 8);
    chk(mode_mon == 1'b1, "R3", "mode after wrap", mode_mon, 1);
    // monitor frame with reset line 50; request beyond limit for next frame (R4)
    lines(200, 12);
    integ_line = 11'd500;
    lines(115, 12);
    // monitor frame with clamped reset line; switch back to still mid-frame
    lines(150, 12);
    mode_sel = 1'b0; integ_line = 11'd1000;
    lines(165, 12);
    chk(mode_mon == 1'b0, "R3", "still after wrap", mode_mon, 0);
    // still frame with reset line 1000, varied spacing
    lines(1000, 9);
    lines(1040, 8);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule